// File: doc/BRIEF.md
# Disk Sector Serializer With CRC

This block moves one disk sector at a time between a byte-wide data side and a one-bit-per-clock serial line, in either direction. On the write side, a start pulse makes it emit the whole sector frame on its own. The frame is a run of zero bits, one '1' bit that marks alignment, the two-byte sector address, the data bytes pulled through a valid/ready handshake, a 16-bit check word, and two all-zero 16-bit words. The data bytes go through two holding registers used in turn: one byte shifts out while the next one loads.

On the read side, a start pulse arms a search. The block skips zeros until the first '1', then takes in the two address bytes and compares them with the expected sector address. On a match it delivers each data byte with a one-cycle valid pulse. It then takes in the received check word and reports whether the running CRC is zero. On a mismatch it flags the miss, skips the rest of that sector's body and searches again. The check word is CRC-16 with polynomial x^16+x^12+x^5+1, preset to zero, bit-serial, MSB first, and covers the address and the data. Clock recovery and line coding are handled elsewhere.

Top module: `sector_serdes`

## Requirements
- R1: After `wr_start`, `ser_out` carries exactly PRE_BITS zero bits, starting in the cycle after the start edge, followed by a single '1' bit.
- R2: Straight after the '1' bit, the write stream carries `sec_addr[15:8]` and then `sec_addr[7:0]`, each MSB first, using the address sampled at start.
- R3: The write stream then carries exactly DATA_BYTES bytes in the order accepted on `wr_byte` (accepted when `wr_valid` and `wr_ready` are both high at a clock edge), each MSB first. The bytes are buffered in two alternating holding registers, so exactly DATA_BYTES handshakes take place.
- R4: Straight after the last data bit, 16 check bits are sent MSB first: the CRC (polynomial 0x1021, preset 0x0000, no final inversion) over the address and data bits.
- R5: The check word is followed by 32 zero bits. `wr_done` is high for exactly one cycle, the cycle after the last postamble bit.
- R6: After `rd_start`, zero bits on `ser_in` are ignored until the first '1', and the address field starts on the bit after that '1', whatever the preamble length.
- R7: When the received address equals `sec_addr` (sampled at `rd_start`), every data byte appears on `rd_byte` (assembled MSB first) with a one-cycle `rd_valid` pulse, DATA_BYTES pulses in all.
- R8: When the received address differs, `hdr_miss` pulses once, no byte is delivered, the next 8*DATA_BYTES+16 bits are skipped and the search for a '1' starts again.
- R9: After the 16 received check bits of a matching sector, `rd_done` pulses for one cycle. `crc_bad` is high in that same cycle exactly when the CRC register is not zero.
- R10: After reset, `wr_ready`, `ser_out`, `rd_valid`, `hdr_miss`, `crc_bad`, `wr_done` and `rd_done` are all low.
- R11: A sector written by the block and fed back into `ser_in` is read back with the same bytes and no check-word error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_addr | input | 16 | Sector address to write, or the address to expect when reading |
| wr_start | input | 1 | Start pulse for sending one sector |
| wr_byte | input | 8 | Data byte offered for writing |
| wr_valid | input | 1 | `wr_byte` is valid |
| wr_ready | output | 1 | A holding register is free for the next byte |
| ser_out | output | 1 | Serial write stream |
| rd_start | input | 1 | Start pulse for the sector search |
| ser_in | input | 1 | Serial read stream |
| rd_byte | output | 8 | Last received data byte |
| rd_valid | output | 1 | One-cycle pulse: `rd_byte` is new |
| hdr_miss | output | 1 | One-cycle pulse: received address differs |
| crc_bad | output | 1 | With `rd_done`: check word did not give zero |
| wr_done | output | 1 | One-cycle pulse: write frame finished |
| rd_done | output | 1 | One-cycle pulse: read check finished |

## Verification
Two write sectors use different addresses and different byte patterns, one of them with alternating all-ones and all-zero bytes. The bit stream is compared segment by segment against a frame built independently in the bench, so that a wrong preamble length, a swapped header byte, a wrong byte order and a wrong CRC each show up in their own segment. The read tests drive a clean sector, a sector with one data bit flipped, a sector with one check bit flipped, and a wrong-address sector followed by the right one. These separate correct delivery from CRC detection over the data and the check field, and from the skip-and-search path. A loopback run joins both halves, so the generator and the checker have to agree on polynomial, bit order and coverage.

// File: rtl/sector_pkg.sv
package sector_pkg;

    localparam int ADDR_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int CRC_W      = 16;
    localparam int POST_WORDS = 2;
    localparam int POST_BITS  = POST_WORDS * CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        TX_IDLE, TX_PRE, TX_SYNC, TX_HDR, TX_DATA, TX_CRC, TX_POST
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_HUNT, RX_HDR, RX_DATA, RX_CRC, RX_CHECK, RX_SKIP
    } rx_state_e;

endpackage

// File: rtl/sector_crc.sv
module sector_crc #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] crc
);

    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[W-1] ^ bit_in;
        if (clr) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == '0)); // R4

endmodule

// File: rtl/sector_tx.sv
module sector_tx
    import sector_pkg::*;
#(
    parameter int DATA_BYTES = 256,
    parameter int PRE_BITS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              ser_out,
    output logic              done
);

    localparam int DATA_BITS = DATA_BYTES * BYTE_W;
    localparam int SPAN0     = (DATA_BITS > PRE_BITS) ? DATA_BITS : PRE_BITS;
    localparam int SPAN      = (SPAN0 > POST_BITS) ? SPAN0 : POST_BITS;
    localparam int CNT_W     = $clog2(SPAN + 1);
    localparam int LEFT_W    = $clog2(DATA_BYTES + 1);

    typedef struct packed {
        tx_state_e                   st;
        logic [CNT_W-1:0]            cnt;
        logic [ADDR_W-1:0]           hdr;
        logic [1:0][BYTE_W-1:0]      slot;
        logic [1:0]                  full;
        logic                        rp;
        logic                        wp;
        logic [LEFT_W-1:0]           left;
        logic                        done;
    } tx_regs_t;

    tx_regs_t         r_d, r_q;
    logic             crc_clr, crc_en;
    logic [CRC_W-1:0] crc_val;

    sector_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .en     (crc_en),
        .bit_in (ser_out),
        .crc    (crc_val)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;

        crc_clr  = start && (r_q.st == TX_IDLE);
        crc_en   = (r_q.st == TX_HDR) || (r_q.st == TX_DATA) || (r_q.st == TX_CRC);

        in_ready = (r_q.st != TX_IDLE) && (r_q.left != '0) && !r_q.full[r_q.wp]
                   && !((r_q.st == TX_DATA) && (r_q.wp == r_q.rp));

        unique case (r_q.st)
            TX_SYNC: ser_out = 1'b1;
            TX_HDR:  ser_out = r_q.hdr[ADDR_W-1];
            TX_DATA: ser_out = r_q.slot[r_q.rp][BYTE_W-1];
            TX_CRC:  ser_out = crc_val[CRC_W-1];
            default: ser_out = 1'b0;
        endcase

        if (in_ready && in_valid) begin
            r_d.slot[r_q.wp] = in_byte;
            r_d.full[r_q.wp] = 1'b1;
            r_d.wp           = ~r_q.wp;
            r_d.left         = r_q.left - 1'b1;
        end

        unique case (r_q.st)
            TX_IDLE: begin
                if (start) begin
                    r_d.st   = TX_PRE;
                    r_d.cnt  = '0;
                    r_d.hdr  = addr;
                    r_d.full = '0;
                    r_d.slot = '0;
                    r_d.rp   = 1'b0;
                    r_d.wp   = 1'b0;
                    r_d.left = LEFT_W'(DATA_BYTES);
                end
            end
            TX_PRE: begin
                if (r_q.cnt == CNT_W'(PRE_BITS - 1)) begin
                    r_d.st  = TX_SYNC;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            TX_SYNC: begin
                r_d.st  = TX_HDR;
                r_d.cnt = '0;
            end
            TX_HDR: begin
                r_d.hdr = r_q.hdr << 1;
                if (r_q.cnt == CNT_W'(ADDR_W - 1)) begin
                    r_d.st  = TX_DATA;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            TX_DATA: begin
                r_d.slot[r_q.rp] = r_q.slot[r_q.rp] << 1;
                if (r_q.cnt[2:0] == 3'd7) begin
                    r_d.full[r_q.rp] = 1'b0;
                    r_d.rp           = ~r_q.rp;
                end
                if (r_q.cnt == CNT_W'(DATA_BITS - 1)) begin
                    r_d.st  = TX_CRC;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            TX_CRC: begin
                if (r_q.cnt == CNT_W'(CRC_W - 1)) begin
                    r_d.st  = TX_POST;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            TX_POST: begin
                if (r_q.cnt == CNT_W'(POST_BITS - 1)) begin
                    r_d.st   = TX_IDLE;
                    r_d.cnt  = '0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done = r_q.done;

    AST_TX_DONE_AFTER_POST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(r_q.st) == TX_POST)); // R5
    AST_TX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_TX_ALL_FETCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == TX_CRC) && ($past(r_q.st) == TX_DATA)) |-> (r_q.left == '0)); // R3

endmodule

// File: rtl/sector_rx.sv
module sector_rx
    import sector_pkg::*;
#(
    parameter int DATA_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ser_in,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid,
    output logic              miss,
    output logic              bad,
    output logic              done
);

    localparam int DATA_BITS = DATA_BYTES * BYTE_W;
    localparam int SKIP_BITS = DATA_BITS + CRC_W;
    localparam int CNT_W     = $clog2(SKIP_BITS + 1);

    typedef struct packed {
        rx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   expect_addr;
        logic [ADDR_W-1:0]   hdr;
        logic [BYTE_W-1:0]   sh;
        logic [BYTE_W-1:0]   obyte;
        logic                valid;
        logic                miss;
        logic                bad;
        logic                done;
    } rx_regs_t;

    rx_regs_t          r_d, r_q;
    logic              crc_clr, crc_en;
    logic [CRC_W-1:0]  crc_val;
    logic [ADDR_W-1:0] hdr_next;
    logic [BYTE_W-1:0] sh_next;

    sector_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .en     (crc_en),
        .bit_in (ser_in),
        .crc    (crc_val)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.miss  = 1'b0;
        r_d.bad   = 1'b0;
        r_d.done  = 1'b0;

        hdr_next  = {r_q.hdr[ADDR_W-2:0], ser_in};
        sh_next   = {r_q.sh[BYTE_W-2:0], ser_in};
        crc_clr   = (r_q.st == RX_IDLE) || (r_q.st == RX_HUNT);
        crc_en    = (r_q.st == RX_HDR) || (r_q.st == RX_DATA) || (r_q.st == RX_CRC);

        unique case (r_q.st)
            RX_IDLE: begin
                if (start) begin
                    r_d.st          = RX_HUNT;
                    r_d.expect_addr = addr;
                end
            end
            RX_HUNT: begin
                if (ser_in) begin
                    r_d.st  = RX_HDR;
                    r_d.cnt = '0;
                end
            end
            RX_HDR: begin
                r_d.hdr = hdr_next;
                if (r_q.cnt == CNT_W'(ADDR_W - 1)) begin
                    r_d.cnt = '0;
                    if (hdr_next == r_q.expect_addr) begin
                        r_d.st = RX_DATA;
                    end else begin
                        r_d.st   = RX_SKIP;
                        r_d.miss = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                r_d.sh = sh_next;
                if (r_q.cnt[2:0] == 3'd7) begin
                    r_d.obyte = sh_next;
                    r_d.valid = 1'b1;
                end
                if (r_q.cnt == CNT_W'(DATA_BITS - 1)) begin
                    r_d.st  = RX_CRC;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            RX_CRC: begin
                if (r_q.cnt == CNT_W'(CRC_W - 1)) begin
                    r_d.st  = RX_CHECK;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            RX_CHECK: begin
                r_d.done = 1'b1;
                r_d.bad  = (crc_val != '0);
                r_d.st   = RX_IDLE;
            end
            RX_SKIP: begin
                if (r_q.cnt == CNT_W'(SKIP_BITS - 1)) begin
                    r_d.st  = RX_HUNT;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_byte  = r_q.obyte;
    assign out_valid = r_q.valid;
    assign miss      = r_q.miss;
    assign bad       = r_q.bad;
    assign done      = r_q.done;

    AST_RX_VALID_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(r_q.st) == RX_DATA)); // R7
    AST_RX_MISS_FROM_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> ($past(r_q.st) == RX_HDR)); // R8
    AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_RX_BAD_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> done); // R9

endmodule

// File: rtl/sector_serdes.sv
module sector_serdes
    import sector_pkg::*;
#(
    parameter int DATA_BYTES = 256,
    parameter int PRE_BITS   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] sec_addr,
    input  logic        wr_start,
    input  logic [7:0]  wr_byte,
    input  logic        wr_valid,
    output logic        wr_ready,
    output logic        ser_out,
    input  logic        rd_start,
    input  logic        ser_in,
    output logic [7:0]  rd_byte,
    output logic        rd_valid,
    output logic        hdr_miss,
    output logic        crc_bad,
    output logic        wr_done,
    output logic        rd_done
);

    sector_tx #(.DATA_BYTES(DATA_BYTES), .PRE_BITS(PRE_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wr_start),
        .addr     (sec_addr),
        .in_byte  (wr_byte),
        .in_valid (wr_valid),
        .in_ready (wr_ready),
        .ser_out  (ser_out),
        .done     (wr_done)
    );

    sector_rx #(.DATA_BYTES(DATA_BYTES)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rd_start),
        .addr      (sec_addr),
        .ser_in    (ser_in),
        .out_byte  (rd_byte),
        .out_valid (rd_valid),
        .miss      (hdr_miss),
        .bad       (crc_bad),
        .done      (rd_done)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!wr_done && !rd_done && !rd_valid && !hdr_miss)); // R10

endmodule

// File: tb/sector_serdes_tb_top.sv
`timescale 1ns/1ps
module sector_serdes_tb_top;

    localparam int N      = 16;
    localparam int PRE    = 12;
    localparam int FLEN   = PRE + 1 + 16 + 8*N + 16 + 32;
    localparam int FR_MAX = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] sec_addr = '0;
    logic       wr_start = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       wr_valid = 1'b0;
    logic       wr_ready, ser_out;
    logic       rd_start = 1'b0;
    logic       ser_drv = 1'b0;
    logic       loop_en = 1'b0;
    logic       ser_in;
    logic [7:0] rd_byte;
    logic       rd_valid, hdr_miss, crc_bad, wr_done, rd_done;

    assign ser_in = loop_en ? ser_out : ser_drv;

    always #2.5 clk = ~clk;

    sector_serdes #(.DATA_BYTES(N), .PRE_BITS(PRE)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_addr(sec_addr), .wr_start(wr_start),
        .wr_byte(wr_byte), .wr_valid(wr_valid), .wr_ready(wr_ready), .ser_out(ser_out),
        .rd_start(rd_start), .ser_in(ser_in), .rd_byte(rd_byte), .rd_valid(rd_valid),
        .hdr_miss(hdr_miss), .crc_bad(crc_bad), .wr_done(wr_done), .rd_done(rd_done)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic fr [FR_MAX];
    int   fr_len;
    logic [7:0] expd [N];
    logic [7:0] got  [N];
    int   ngot, nmiss, ndone, stray_bad, dbl_done;
    logic bad_at_done, prev_done;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37) + (i * 13) + (i >> 1));
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    // Appends one full sector frame; data byte i is pat(seed,i), or alt pattern when alt set.
    task automatic add_frame(input logic [15:0] a, input int seed, input bit alt,
                             input bit record, input int flip);
        logic [15:0] c;
        logic [7:0]  b;
        int          base;
        base = fr_len;
        c = 16'h0000;
        for (int i = 0; i < PRE; i++) begin fr[fr_len] = 1'b0; fr_len++; end
        fr[fr_len] = 1'b1; fr_len++;
        for (int i = 15; i >= 0; i--) begin
            fr[fr_len] = a[i]; c = crc_step(c, a[i]); fr_len++;
        end
        for (int k = 0; k < N; k++) begin
            b = alt ? ((k % 2 == 0) ? 8'hFF : 8'h00) : pat(seed, k);
            if (record) expd[k] = b;
            for (int i = 7; i >= 0; i--) begin
                fr[fr_len] = b[i]; c = crc_step(c, b[i]); fr_len++;
            end
        end
        for (int i = 15; i >= 0; i--) begin fr[fr_len] = c[i]; fr_len++; end
        for (int i = 0; i < 32; i++) begin fr[fr_len] = 1'b0; fr_len++; end
        if (flip >= 0) fr[base + flip] = ~fr[base + flip];
    endtask

    task automatic clear_mon();
        ngot = 0; nmiss = 0; ndone = 0; stray_bad = 0; dbl_done = 0;
        bad_at_done = 1'b0; prev_done = 1'b0;
    endtask

    task automatic mon_sample();
        if (rd_valid) begin
            if (ngot < N) got[ngot] = rd_byte;
            ngot++;
        end
        if (hdr_miss) nmiss++;
        if (rd_done) begin ndone++; bad_at_done = crc_bad; end
        if (crc_bad && !rd_done) stray_bad++;
        if (rd_done && prev_done) dbl_done++;
        prev_done = rd_done;
    endtask

    function automatic int byte_errs();
        int e;
        e = 0;
        for (int k = 0; k < N; k++) if (got[k] !== expd[k]) e++;
        return e;
    endfunction

    // Write one sector and compare the captured stream with the bench-built frame.
    task automatic run_write(input logic [15:0] a, input int seed, input bit alt, input string tag);
        logic cap [FR_MAX];
        int   nbits, idx, e_pre, e_hdr, e_dat, e_crc, e_post;
        bit   pend, seen_done;
        fr_len = 0;
        add_frame(a, seed, alt, 1'b1, -1);
        idx = 0; pend = 1'b0; nbits = 0; seen_done = 1'b0;
        sec_addr = a; wr_byte = expd[0]; wr_valid = 1'b1; wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        for (int cyc = 0; cyc < FR_MAX; cyc++) begin
            if (pend) begin
                idx++;
                wr_valid = (idx < N);
                wr_byte  = (idx < N) ? expd[idx] : 8'h00;
            end
            pend = wr_ready && wr_valid;
            mon_sample();
            if (wr_done) begin seen_done = 1'b1; break; end
            cap[nbits] = ser_out;
            nbits++;
            @(negedge clk);
        end
        chk(seen_done && nbits == FLEN, {tag, " R5 frame length"}, nbits, FLEN);
        e_pre = 0; e_hdr = 0; e_dat = 0; e_crc = 0; e_post = 0;
        for (int i = 0; i < FLEN && i < nbits; i++) begin
            if (cap[i] !== fr[i]) begin
                if (i <= PRE)                 e_pre++;
                else if (i <= PRE + 16)       e_hdr++;
                else if (i <= PRE + 16 + 8*N) e_dat++;
                else if (i <= PRE + 32 + 8*N) e_crc++;
                else                          e_post++;
            end
        end
        chk(e_pre == 0,  {tag, " R1 preamble and sync bit"}, e_pre, 0);
        chk(e_hdr == 0,  {tag, " R2 header bytes"}, e_hdr, 0);
        chk(e_dat == 0,  {tag, " R3 data bytes"}, e_dat, 0);
        chk(idx == N,    {tag, " R3 handshake count"}, idx, N);
        chk(e_crc == 0,  {tag, " R4 check word"}, e_crc, 0);
        chk(e_post == 0, {tag, " R5 postamble zeros"}, e_post, 0);
        @(negedge clk);
        chk(!wr_done, {tag, " R5 done single cycle"}, int'(wr_done), 0);
        wr_valid = 1'b0;
    endtask

    // Drive fr[] into ser_in after arming a read for address a.
    task automatic run_read(input logic [15:0] a, input int lead);
        clear_mon();
        sec_addr = a; rd_start = 1'b1; ser_drv = 1'b0;
        @(negedge clk);
        rd_start = 1'b0;
        for (int i = 0; i < lead; i++) begin mon_sample(); ser_drv = 1'b0; @(negedge clk); end
        for (int i = 0; i < fr_len; i++) begin mon_sample(); ser_drv = fr[i]; @(negedge clk); end
        for (int i = 0; i < 40; i++) begin mon_sample(); ser_drv = 1'b0; @(negedge clk); end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!wr_ready && !ser_out && !rd_valid && !hdr_miss && !crc_bad && !wr_done && !rd_done,
            "R10 reset outputs", int'({wr_ready, ser_out, rd_valid, hdr_miss, crc_bad, wr_done, rd_done}), 0);
    endtask

    task automatic t_write_a();
        run_write(16'h1234, 1, 1'b0, "write A");
    endtask

    task automatic t_write_b();
        run_write(16'hA5C3, 0, 1'b1, "write B");
    endtask

    task automatic t_read_good();
        fr_len = 0;
        add_frame(16'h0F0E, 7, 1'b0, 1'b1, -1);
        run_read(16'h0F0E, 9);
        chk(ngot == N, "R7 byte count", ngot, N);
        chk(byte_errs() == 0, "R7 byte values", byte_errs(), 0);
        chk(ndone == 1 && dbl_done == 0, "R9 done pulse", ndone, 1);
        chk(!bad_at_done && stray_bad == 0, "R9 clean crc", int'(bad_at_done), 0);
        chk(nmiss == 0, "R6 alignment after leading zeros", nmiss, 0);
    endtask

    task automatic t_read_bad_data();
        fr_len = 0;
        add_frame(16'h0F0E, 7, 1'b0, 1'b1, PRE + 17 + 8*5 + 3);
        run_read(16'h0F0E, 0);
        chk(ndone == 1 && bad_at_done, "R9 data bit error flagged", int'(bad_at_done), 1);
    endtask

    task automatic t_read_bad_crc();
        fr_len = 0;
        add_frame(16'h4242, 2, 1'b0, 1'b1, PRE + 17 + 8*N + 15);
        run_read(16'h4242, 3);
        chk(ndone == 1 && bad_at_done, "R9 check-bit error flagged", int'(bad_at_done), 1);
        chk(ngot == N, "R7 bytes still delivered", ngot, N);
    endtask

    task automatic t_read_miss();
        fr_len = 0;
        add_frame(16'h7700, 3, 1'b0, 1'b0, -1);
        add_frame(16'h7701, 5, 1'b0, 1'b1, -1);
        run_read(16'h7701, 4);
        chk(nmiss == 1, "R8 miss pulse", nmiss, 1);
        chk(ngot == N, "R8 only matching sector bytes", ngot, N);
        chk(byte_errs() == 0, "R8 bytes from second sector", byte_errs(), 0);
        chk(ndone == 1 && !bad_at_done, "R8 second sector good", ndone, 1);
    endtask

    task automatic t_loopback();
        clear_mon();
        loop_en = 1'b1;
        sec_addr = 16'hBEEF; rd_start = 1'b1;
        run_write(16'hBEEF, 9, 1'b0, "loopback");
        rd_start = 1'b0;
        for (int i = 0; i < 8; i++) begin mon_sample(); @(negedge clk); end
        chk(ndone == 1 && !bad_at_done, "R11 loopback crc", int'(bad_at_done), 0);
        chk(ngot == N && byte_errs() == 0, "R11 loopback bytes", byte_errs(), 0);
        loop_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_a();
        t_write_b();
        t_read_good();
        t_read_bad_data();
        t_read_bad_crc();
        t_read_miss();
        t_loopback();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule